// File: doc/BRIEF.md
# Prescaled Timer with Output Compare

The block keeps a 16-bit up-counter that advances once per tick of a selectable clock divider. Five compare channels watch that counter. Four of them each own one output pin and apply a small per-pin action when the counter reaches their compare value. The fifth, the master channel, writes a data pattern onto any subset of the same pins, chosen by a mask. Each channel, and the counter wrap, sets its own sticky flag. A flag raises an interrupt line when its enable bit is set. Software clears a flag by writing a one to it.

Software reaches the block through a single-cycle register write port and a combinational read port. A force strobe per channel applies that channel's pin action at once, as if a match had happened. A forced action sets no flag. A pin that no channel drives shows a software-written latch value instead.

Top module: `ptmr_oc_top`

## Requirements
- R1: The divider select at address 0 bits [1:0] picks a tick every 1 (value 0), 4 (1), 8 (2) or 16 (3) clock cycles, and the counter advances by one on each tick.
- R2: A write to the divider select takes effect only when it falls in the first 64 clock cycles after reset release. Later writes leave the select unchanged.
- R3: The counter (read at address 7) is 0 after reset. It steps by one and wraps from 0xFFFF to 0x0000. Writes to address 7 have no effect.
- R4: The wrap from 0xFFFF to 0x0000 sets flag bit 5 (address 3). `irq_ovf` is high while that flag and enable bit 5 (address 2) are both set.
- R5: A compare register matches on the clock edge at which the counter advances to its value. The registers are at address 8 for the master and at 9+i for pin channel i. A match sets flag bit 0 for the master or bit i+1 for channel i, and `irq_cmp[k]` equals flag bit k AND enable bit k.
- R6: Writing a one to a flag bit at address 3 clears it, and writing a zero leaves it unchanged. A set in the same cycle wins over a clear.
- R7: Channel i takes its action from bits [2i+1:2i] of address 1: 00 disconnects the pin, 01 toggles it, 10 drives it low and 11 drives it high on a match.
- R8: `force_stb[k]` (bit 0 for the master, bit i+1 for channel i) applies that channel's pin action in the same way as a match. It does not set a flag, raise an interrupt, or change a compare register or the counter.
- R9: On a master match or master force, each pin whose bit is set in the mask (address 4) takes the matching bit of the data register (address 5).
- R10: When the master and a pin channel act on the same pin in the same cycle, the master value is the one applied.
- R11: A pin whose action is 00 and whose mask bit is clear outputs its bit of the port latch (address 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | CNT_W | Combinational read data |
| force_stb | input | NCH+1 | Force-compare strobes, bit 0 is the master |
| pin_out | output | NCH | Timer pin outputs |
| irq_cmp | output | NCH+1 | Compare interrupt requests, bit 0 is the master |
| irq_ovf | output | 1 | Counter wrap interrupt request |

## Verification
The bench builds the block with its defaults: four pin channels, a 16-bit counter and a 64-cycle prescale window. With divide-by-one the counter wraps within about 65,536 cycles, so one wait reaches the overflow flag and the wrap arithmetic. The window is short enough that one reset phase can test both an accepted write and an ignored write. Divides of 4 and 16 are measured across fixed 400-cycle spans. This gives exact tick counts.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
   localparam int ADDR_W  = 4;
   localparam int SEL_W   = 2;
   localparam int A_PRESC = 0;
   localparam int A_ACT   = 1;
   localparam int A_IEN   = 2;
   localparam int A_FLAG  = 3;
   localparam int A_MASK  = 4;
   localparam int A_MDATA = 5;
   localparam int A_LATCH = 6;
   localparam int A_COUNT = 7;
   localparam int A_CMP0  = 8;

   typedef enum logic [1:0] {
      ACT_OFF  = 2'b00,
      ACT_TGL  = 2'b01,
      ACT_LOW  = 2'b10,
      ACT_HIGH = 2'b11
   } act_e;
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
   import ptmr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int PRE_W = 4;
   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] lim;

   always_comb begin
      case (sel)
         2'd0:    lim = PRE_W'(0);
         2'd1:    lim = PRE_W'(3);
         2'd2:    lim = PRE_W'(7);
         default: lim = PRE_W'(15);
      endcase
   end

   assign tick = (pre_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre_q <= '0;
      else if (tick) pre_q <= '0;
      else           pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] nxt,
   output logic             wrap
);
   assign nxt  = cnt + 1'b1;
   assign wrap = tick & (&cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= nxt;
   end
endmodule

// File: rtl/ptmr_cmp.sv
module ptmr_cmp #(
   parameter int CNT_W = 16
) (
   input  logic             tick,
   input  logic [CNT_W-1:0] nxt,
   input  logic [CNT_W-1:0] cmp,
   output logic             match
);
   assign match = tick && (nxt == cmp);
endmodule

// File: rtl/ptmr_pin_act.sv
module ptmr_pin_act
   import ptmr_pkg::*;
(
   input  logic [1:0] act,
   input  logic       hit,
   input  logic       cur,
   output logic       apply,
   output logic       val
);
   act_e mode;
   assign mode  = act_e'(act);
   assign apply = hit && (mode != ACT_OFF);

   always_comb begin
      case (mode)
         ACT_TGL:  val = ~cur;
         ACT_LOW:  val = 1'b0;
         ACT_HIGH: val = 1'b1;
         default:  val = cur;
      endcase
   end
endmodule

// File: rtl/ptmr_oc_top.sv
module ptmr_oc_top
   import ptmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int NCH         = 4,
   parameter int LOCK_CYCLES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   input  logic [NCH:0]      force_stb,
   output logic [NCH-1:0]    pin_out,
   output logic [NCH:0]      irq_cmp,
   output logic              irq_ovf
);
   localparam int FLG_W = NCH + 2;
   localparam int ACT_W = 2 * NCH;
   localparam int NCMP  = NCH + 1;

   if (NCH < 1 || A_CMP0 + NCH >= (1 << ADDR_W)) begin : g_bad_nch
      $error("ptmr_oc_top: NCH out of range for the address space");
   end
   if (CNT_W < ACT_W || CNT_W < FLG_W) begin : g_bad_w
      $error("ptmr_oc_top: CNT_W too narrow for the control fields");
   end

   logic [SEL_W-1:0] presc_q;
   logic [ACT_W-1:0] act_q;
   logic [FLG_W-1:0] ien_q, flag_q, flag_set, flag_clr;
   logic [NCH-1:0]   mask_q, mdata_q, latch_q, pin_q, conn;
   logic [CNT_W-1:0] cmp_q [NCMP];
   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             tick, wrap, lock_open;
   logic [NCH:0]     match;
   logic [NCH-1:0]   ch_apply, ch_val;

   if (LOCK_CYCLES > 0) begin : g_lock
      localparam int LW = $clog2(LOCK_CYCLES + 1);
      logic [LW-1:0] lk_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      lk_q <= '0;
         else if (lk_q != LW'(LOCK_CYCLES)) lk_q <= lk_q + 1'b1;
      end
      assign lock_open = (lk_q != LW'(LOCK_CYCLES));
   end else begin : g_nolock
      assign lock_open = 1'b1;
   end

   ptmr_prescaler u_pre (.clk(clk), .rst_n(rst_n), .sel(presc_q), .tick(tick));

   ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .cnt(cnt_q), .nxt(cnt_nxt), .wrap(wrap)
   );

   for (genvar k = 0; k < NCMP; k++) begin : g_cmp
      ptmr_cmp #(.CNT_W(CNT_W)) u_cmp (
         .tick(tick), .nxt(cnt_nxt), .cmp(cmp_q[k]), .match(match[k])
      );
   end

   for (genvar i = 0; i < NCH; i++) begin : g_pin
      ptmr_pin_act u_act (
         .act(act_q[2*i +: 2]),
         .hit(match[i+1] | force_stb[i+1]),
         .cur(pin_q[i]),
         .apply(ch_apply[i]),
         .val(ch_val[i])
      );
      assign conn[i]    = mask_q[i] | (act_q[2*i +: 2] != 2'b00);
      assign pin_out[i] = conn[i] ? pin_q[i] : latch_q[i];
   end

   function automatic logic wr_hit(input int a);
      return wr_en && (wr_addr == ADDR_W'(a));
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc_q <= '0;
         act_q   <= '0;
         ien_q   <= '0;
         mask_q  <= '0;
         mdata_q <= '0;
         latch_q <= '0;
         for (int k = 0; k < NCMP; k++) cmp_q[k] <= '0;
      end else begin
         if (wr_hit(A_PRESC) && lock_open) presc_q <= wr_data[SEL_W-1:0];
         if (wr_hit(A_ACT))   act_q   <= wr_data[ACT_W-1:0];
         if (wr_hit(A_IEN))   ien_q   <= wr_data[FLG_W-1:0];
         if (wr_hit(A_MASK))  mask_q  <= wr_data[NCH-1:0];
         if (wr_hit(A_MDATA)) mdata_q <= wr_data[NCH-1:0];
         if (wr_hit(A_LATCH)) latch_q <= wr_data[NCH-1:0];
         for (int k = 0; k < NCMP; k++)
            if (wr_hit(A_CMP0 + k)) cmp_q[k] <= wr_data;
      end
   end

   assign flag_set = {wrap, match};
   assign flag_clr = wr_hit(A_FLAG) ? wr_data[FLG_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~flag_clr) | flag_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= '0;
      else begin
         for (int i = 0; i < NCH; i++) begin
            if ((match[0] | force_stb[0]) && mask_q[i]) pin_q[i] <= mdata_q[i];
            else if (ch_apply[i])                      pin_q[i] <= ch_val[i];
         end
      end
   end

   assign irq_cmp = flag_q[NCH:0] & ien_q[NCH:0];
   assign irq_ovf = flag_q[NCH+1] & ien_q[NCH+1];

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_W'(A_PRESC): rd_data[SEL_W-1:0] = presc_q;
         ADDR_W'(A_ACT):   rd_data[ACT_W-1:0] = act_q;
         ADDR_W'(A_IEN):   rd_data[FLG_W-1:0] = ien_q;
         ADDR_W'(A_FLAG):  rd_data[FLG_W-1:0] = flag_q;
         ADDR_W'(A_MASK):  rd_data[NCH-1:0]   = mask_q;
         ADDR_W'(A_MDATA): rd_data[NCH-1:0]   = mdata_q;
         ADDR_W'(A_LATCH): rd_data[NCH-1:0]   = latch_q;
         ADDR_W'(A_COUNT): rd_data            = cnt_q;
         default: begin
            for (int k = 0; k < NCMP; k++)
               if (rd_addr == ADDR_W'(A_CMP0 + k)) rd_data = cmp_q[k];
         end
      endcase
   end
endmodule

// File: rtl/ptmr_oc_chk.sv
module ptmr_oc_chk
   import ptmr_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int NCH   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W-1:0]  cnt,
   input logic [NCH+1:0]    flags,
   input logic [SEL_W-1:0]  presc,
   input logic              lock_open,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr
);
   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1)));

   // R4
   wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((&$past(cnt)) && (cnt == '0)) |-> flags[NCH+1]);

   // R2
   presc_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_open |=> $stable(presc));

   // R6
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(flags) & ~flags)) |-> $past(wr_en && wr_addr == ADDR_W'(A_FLAG)));

   // R8
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flags[NCH:0] & ~$past(flags[NCH:0]))) |-> (cnt != $past(cnt)));
endmodule

bind ptmr_oc_top ptmr_oc_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .flags(flag_q),
   .presc(presc_q), .lock_open(lock_open),
   .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/test_ptmr_oc_top.sv
module test_ptmr_oc_top;
   localparam int W = 16;
   localparam int N = 4;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [3:0]    wr_addr = '0, rd_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [W-1:0]  rd_data;
   logic [N:0]    force_stb = '0;
   logic [N-1:0]  pin_out;
   logic [N:0]    irq_cmp;
   logic          irq_ovf;

   always #10 clk = ~clk;

   ptmr_oc_top #(.CNT_W(W), .NCH(N), .LOCK_CYCLES(64)) i_ptmr_oc_top (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .force_stb(force_stb), .pin_out(pin_out), .irq_cmp(irq_cmp),
      .irq_ovf(irq_ovf)
   );

   typedef struct {
      string       req;
      logic [31:0] exp;
      logic [31:0] act;
   } item_t;

   item_t sb_q[$];
   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   task automatic push(input string r, input logic [31:0] e, input logic [31:0] a);
      item_t it;
      it.req = r; it.exp = e; it.act = a;
      sb_q.push_back(it);
   endtask

   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         n_cmp++;
         if (it.act !== it.exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", it.req, it.act, it.exp);
         end
      end
   end

   task automatic wr(input int a, input logic [W-1:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [W-1:0] v);
      @(negedge clk); rd_addr = 4'(a); #1 v = rd_data;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      idle(4);
      rst_n = 1'b1;
   endtask

   task automatic fstb(input logic [N:0] b);
      @(negedge clk); force_stb = b;
      @(negedge clk); force_stb = '0;
   endtask

   task automatic arm(input int a, input int delta);
      logic [W-1:0] c;
      rd(7, c);
      wr(a, W'(c + delta));
   endtask

   task automatic rate(input string r, input int exp_ticks, input bit poke_cnt);
      logic [W-1:0] c0, c1;
      rd(7, c0);
      if (poke_cnt) begin wr(7, 16'h1234); idle(397); end
      else idle(399);
      rd(7, c1);
      push(r, exp_ticks, 32'(W'(c1 - c0)));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog(all) actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] v, v2;
      // phase 1: divide by 4, then a late write
      do_reset();
      rd(3, v);  push("R3 reset flags", 0, 32'(v));
      push("R11 reset pins", 0, 32'(pin_out));
      push("R5 reset irq", 0, 32'({irq_ovf, irq_cmp}));
      wr(0, 16'd1);
      rd(0, v);  push("R2 early presc write", 1, 32'(v));
      rate("R1 div4", 100, 1'b0);
      wr(0, 16'd3);
      rd(0, v);  push("R2 late presc ignored", 1, 32'(v));
      rate("R3 count write ignored", 100, 1'b1);

      // phase 2: divide by 16
      do_reset();
      wr(0, 16'd3);
      rate("R1 div16", 25, 1'b0);

      // phase 3: divide by 1
      do_reset();
      rate("R1 div1", 400, 1'b0);
      wr(1, 16'h001B);            // ch3 off, ch2 toggle, ch1 low, ch0 high
      wr(6, 16'h0008);
      idle(1);
      push("R11 latch on free pin", 4'b1000, 32'(pin_out));
      wr(2, 16'h0002);
      arm(9, 30); idle(50);
      rd(3, v);  push("R5 ch0 flag", 16'h0002, 32'(v));
      push("R5 ch0 irq", 5'b00010, 32'(irq_cmp));
      push("R7 drive high", 4'b1001, 32'(pin_out));
      wr(3, 16'h0000);
      rd(3, v);  push("R6 write zero keeps", 16'h0002, 32'(v));
      wr(3, 16'h0002);
      rd(3, v);  push("R6 write one clears", 0, 32'(v));
      push("R6 irq drops", 0, 32'(irq_cmp));

      arm(11, 30); idle(50);
      push("R7 toggle up", 4'b1101, 32'(pin_out));
      arm(11, 30); idle(50);
      push("R7 toggle down", 4'b1001, 32'(pin_out));
      wr(3, 16'h003F);

      rd(11, v);
      fstb(5'b01000); idle(1);
      push("R8 force toggles", 4'b1101, 32'(pin_out));
      rd(3, v2); push("R8 force no flag", 0, 32'(v2));
      push("R8 force no irq", 0, 32'(irq_cmp));
      rd(11, v2); push("R8 compare kept", 32'(v), 32'(v2));

      wr(4, 16'h0003);
      wr(5, 16'h0002);
      arm(8, 30); idle(50);
      push("R9 master pattern", 4'b1110, 32'(pin_out));
      rd(3, v);  push("R5 master flag", 16'h0001, 32'(v & 16'h0001));

      wr(3, 16'h003F);
      wr(4, 16'h0001);
      wr(5, 16'h0001);
      wr(1, 16'h001A);            // ch0 now drives low
      rd(7, v);
      wr(8, W'(v + 40));
      wr(9, W'(v + 40));
      idle(60);
      push("R10 master wins", 4'b1111, 32'(pin_out));
      rd(3, v);  push("R10 both matched", 16'h0003, 32'(v & 16'h0003));

      wr(3, 16'h003F);
      wr(2, 16'h0020);
      rd(3, v);  push("R4 no early wrap", 0, 32'(v & 16'h0020));
      push("R4 irq low", 0, 32'(irq_ovf));
      rd(7, v);
      idle(65999);
      rd(7, v2); push("R3 wrap arithmetic", 464, 32'(W'(v2 - v)));
      rd(3, v);  push("R4 wrap flag", 16'h0020, 32'(v & 16'h0020));
      push("R4 wrap irq", 1, 32'(irq_ovf));

      idle(3);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule